// File: doc/BRIEF.md
# Codec Power and Control Sequencer

This block is the control core of a voice codec. Software sends it commands over a three-wire serial control port: a select line held low for the whole frame, a shift clock, and a data line sampled MSB first on each rising shift clock. A frame is one instruction byte, or one instruction byte followed by one data byte. The block keeps a bank of eight-bit control registers and drives the configuration fields that the analog and coding paths need. It also runs a power state machine whose up/down request rides inside every instruction.

Once powered up, the block holds the PCM transmit output enable low until two frame-sync pulses have been seen. After that the enable follows the transmit time-slot input. A watchdog, clocked by the free-running reference clock, looks for activity on the master clock. When the master clock stops, the block drops into a forced power-down with the transmit output disabled. A status flag shows whether an internal power-on reset has taken place since software cleared it.

All control inputs are asynchronous to the reference clock. Each one passes through a two-flop synchronizer, so any input change shows up at the outputs three reference-clock edges after the edge that first captures it.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rst` is high and after it falls, the block is powered down, `tx_oe` is 0, `mclk_lost` is 0 and `por_flag` is 1. The registers hold their defaults: register 0 = 0x01, register 5 = 0x80, all others 0x00.
- R2: A 16-bit frame whose instruction byte has bit 1 = 1 writes the data byte into the register addressed by instruction bits 7:3. In the same step it applies the power request in instruction bit 2 (0 = power up, 1 = power down). Instruction bit 0 is ignored.
- R3: An 8-bit frame with instruction bit 1 = 0 applies only the power request in bit 2. An 8-bit frame with bit 1 = 1 changes nothing.
- R4: The following frames change no register and no power state: a frame with a bit count other than 8 or 16, a 16-bit frame with instruction bit 1 = 0, and a 16-bit frame addressing a register at or above NREG. Register contents survive power-down.
- R5: After a power-up from the powered-down state, `tx_oe` stays 0 until the second rising frame sync. From then on it equals `tx_slot`.
- R6: If the master clock shows no transition for TIMEOUT reference cycles, `mclk_lost` rises, the block powers down, and `tx_oe` goes to 0. Power-up requests are refused while the condition lasts. When transitions resume, `mclk_lost` clears but the block stays down until a new power-up request.
- R7: `por_flag` is the inverse of bit 0 of register 1. Writing 1 there clears the flag, and any later reset sets it again.
- R8: Field mapping: `cfg_compand` = register 0 bit 0, `mic_sel` = register 4 bits 7:6, `pre_gain_hi` = register 4 bit 1, `pga_step` = register 5 bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_sclk | input | 1 | Serial control shift clock |
| ctl_csn | input | 1 | Serial control frame select, active low |
| ctl_sdi | input | 1 | Serial control data, MSB first |
| mclk | input | 1 | Master clock being watched |
| fsync | input | 1 | PCM frame sync |
| tx_slot | input | 1 | Transmit time slot active |
| pwr_on | output | 1 | Codec functions enabled |
| tx_oe | output | 1 | PCM transmit output enable |
| mclk_lost | output | 1 | Master clock stall detected |
| por_flag | output | 1 | Reset occurred since flag was cleared |
| cfg_compand | output | 1 | 1 = companded coding, 0 = 14-bit linear |
| mic_sel | output | 2 | Transmit input select or mute |
| pre_gain_hi | output | 1 | First-stage gain: 1 = high setting |
| pga_step | output | 4 | Second-stage gain step |

## Verification
Register contents are always visible on the configuration field outputs. A wrong write, or a write that should have been dropped, therefore shows up on those pins three reference cycles after the frame select rises. A bad power or frame-sync count appears as `pwr_on` or `tx_oe` changing one frame sync early or late, or at a frame-select edge where it should not. A wrong watchdog count moves the rising edge of `mclk_lost`. The bench compares every output with a behavioural model on every clock, so each of these faults is reported within the cycle it first appears.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

  localparam int REG_W     = 8;
  localparam int ADDR_W    = 5;
  localparam int REG_MODE  = 0;
  localparam int REG_FLAG  = 1;
  localparam int REG_INPUT = 4;
  localparam int REG_GAIN  = 5;

  localparam int P_BIT     = 2;
  localparam int MARK_BIT  = 1;
  localparam int SHORT_LEN = 8;
  localparam int LONG_LEN  = 16;

  typedef enum logic [1:0] {
    PS_OFF      = 2'd0,
    PS_WAIT_FS1 = 2'd1,
    PS_WAIT_FS2 = 2'd2,
    PS_LIVE     = 2'd3
  } pwr_state_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  data;
    logic              pcmd;
    logic              pdown;
  } ctl_cmd_t;

  function automatic logic [REG_W-1:0] cfg_default(input int idx);
    case (idx)
      REG_MODE: cfg_default = 8'h01;
      REG_GAIN: cfg_default = 8'h80;
      default:  cfg_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ctl_in_sync.sv
module ctl_in_sync #(
  parameter int           W    = 1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= IDLE;
      cur  <= IDLE;
      prev <= IDLE;
    end else begin
      meta <= d;
      cur  <= meta;
      prev <= cur;
    end
  end
endmodule

// File: rtl/ctl_serial_rx.sv
module ctl_serial_rx
  import codec_ctl_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk_cur,
  input  logic     sclk_prev,
  input  logic     csn_cur,
  input  logic     csn_prev,
  input  logic     sdi_cur,
  output ctl_cmd_t cmd
);
  localparam int               CW    = $clog2(LONG_LEN) + 1;
  localparam logic [CW-1:0]    CMAX  = '1;
  localparam logic [CW-1:0]    N_SH  = CW'(SHORT_LEN);
  localparam logic [CW-1:0]    N_LG  = CW'(LONG_LEN);
  localparam int               SW    = LONG_LEN;

  logic [SW-1:0] shreg;
  logic [CW-1:0] nbits;
  logic          sclk_rise;
  logic          csn_fall;
  logic          csn_rise;
  logic [ADDR_W-1:0] waddr;
  logic          addr_ok;

  assign sclk_rise = sclk_cur & ~sclk_prev;
  assign csn_fall  = ~csn_cur & csn_prev;
  assign csn_rise  = csn_cur & ~csn_prev;
  assign waddr     = shreg[SW-1 -: ADDR_W];
  assign addr_ok   = 32'(waddr) < 32'(NREG);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      nbits <= '0;
    end else if (csn_fall) begin
      nbits <= '0;
    end else if (sclk_rise && !csn_cur) begin
      shreg <= {shreg[SW-2:0], sdi_cur};
      if (nbits != CMAX) nbits <= nbits + 1'b1;
    end
  end

  always_comb begin
    cmd = '0;
    if (csn_rise) begin
      if (nbits == N_SH && !shreg[MARK_BIT]) begin
        cmd.pcmd  = 1'b1;
        cmd.pdown = shreg[P_BIT];
      end else if (nbits == N_LG && shreg[REG_W+MARK_BIT] && addr_ok) begin
        cmd.wr    = 1'b1;
        cmd.addr  = waddr;
        cmd.data  = shreg[REG_W-1:0];
        cmd.pcmd  = 1'b1;
        cmd.pdown = shreg[REG_W+P_BIT];
      end
    end
  end
endmodule

// File: rtl/ctl_clk_watch.sv
module ctl_clk_watch #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic mclk_cur,
  input  logic mclk_prev,
  output logic lost_nxt,
  output logic lost
);
  localparam int            IW   = $clog2(TIMEOUT + 1);
  localparam logic [IW-1:0] TLIM = IW'(TIMEOUT);

  logic [IW-1:0] idle, idle_nxt;

  always_comb begin
    if (mclk_cur != mclk_prev)  idle_nxt = '0;
    else if (idle != TLIM)      idle_nxt = idle + 1'b1;
    else                        idle_nxt = idle;
    lost_nxt = (idle_nxt == TLIM);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idle <= '0;
      lost <= 1'b0;
    end else begin
      idle <= idle_nxt;
      lost <= lost_nxt;
    end
  end
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_ctl_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int TIMEOUT = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_sclk,
  input  logic       ctl_csn,
  input  logic       ctl_sdi,
  input  logic       mclk,
  input  logic       fsync,
  input  logic       tx_slot,
  output logic       pwr_on,
  output logic       tx_oe,
  output logic       mclk_lost,
  output logic       por_flag,
  output logic       cfg_compand,
  output logic [1:0] mic_sel,
  output logic       pre_gain_hi,
  output logic [3:0] pga_step
);
  localparam int          NIN  = 6;
  localparam logic [NIN-1:0] IN_IDLE = 6'b000010;

  logic [NIN-1:0] in_cur, in_prev;
  ctl_cmd_t       cmd;
  logic           lost_nxt;
  logic           fs_rise;
  logic           wr_fire;
  logic           up_fire;
  pwr_state_e     st, st_nxt;
  logic [REG_W-1:0] regs [NREG];

  ctl_in_sync #(.W(NIN), .IDLE(IN_IDLE)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d    ({tx_slot, fsync, mclk, ctl_sdi, ctl_csn, ctl_sclk}),
    .cur  (in_cur),
    .prev (in_prev)
  );

  ctl_serial_rx #(.NREG(NREG)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sclk_cur  (in_cur[0]),
    .sclk_prev (in_prev[0]),
    .csn_cur   (in_cur[1]),
    .csn_prev  (in_prev[1]),
    .sdi_cur   (in_cur[2]),
    .cmd       (cmd)
  );

  ctl_clk_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .mclk_cur  (in_cur[3]),
    .mclk_prev (in_prev[3]),
    .lost_nxt  (lost_nxt),
    .lost      (mclk_lost)
  );

  assign fs_rise = in_cur[4] & ~in_prev[4];
  assign wr_fire = cmd.wr;
  assign up_fire = cmd.pcmd & ~cmd.pdown;

  // control register bank
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                                         regs[i] <= cfg_default(i);
      else if (cmd.wr && 32'(cmd.addr) == 32'(i))      regs[i] <= cmd.data;
    end
  end

  // power sequencing
  always_comb begin
    st_nxt = st;
    if (lost_nxt)                              st_nxt = PS_OFF;
    else if (cmd.pcmd && cmd.pdown)            st_nxt = PS_OFF;
    else if (up_fire && st == PS_OFF)          st_nxt = PS_WAIT_FS1;
    else if (fs_rise) begin
      case (st)
        PS_WAIT_FS1: st_nxt = PS_WAIT_FS2;
        PS_WAIT_FS2: st_nxt = PS_LIVE;
        default:     st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_OFF;
      pwr_on <= 1'b0;
      tx_oe  <= 1'b0;
    end else begin
      st     <= st_nxt;
      pwr_on <= (st_nxt != PS_OFF);
      tx_oe  <= (st_nxt == PS_LIVE) && in_cur[5];
    end
  end

  assign por_flag    = ~regs[REG_FLAG][0];
  assign cfg_compand = regs[REG_MODE][0];
  assign mic_sel     = regs[REG_INPUT][7:6];
  assign pre_gain_hi = regs[REG_INPUT][1];
  assign pga_step    = regs[REG_GAIN][7:4];
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_on,
  input logic       tx_oe,
  input logic       mclk_lost,
  input logic       por_flag,
  input logic       fs_rise,
  input logic       wr_fire,
  input logic       up_fire,
  input logic [8:0] cfg
);
  logic       was_rst = 1'b0;
  logic [1:0] fs_seen;

  always_ff @(posedge clk) begin
    was_rst <= rst;
    if (rst || !pwr_on)              fs_seen <= 2'd0;
    else if (fs_rise && fs_seen != 2'd2) fs_seen <= fs_seen + 2'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    was_rst |-> (por_flag && !pwr_on && !tx_oe && !mclk_lost)); // R1

  AST_UP_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_on) |-> $past(up_fire)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_fire |=> $stable(cfg)); // R4

  AST_OE_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> pwr_on); // R5

  AST_OE_TWO_FS: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> fs_seen == 2'd2); // R5

  AST_LOST_DOWN: assert property (@(posedge clk) disable iff (rst)
    mclk_lost |-> (!pwr_on && !tx_oe)); // R6

  AST_FLAG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(por_flag) |-> $past(wr_fire)); // R7
endmodule

bind codec_pwr_seq codec_pwr_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_on    (pwr_on),
  .tx_oe     (tx_oe),
  .mclk_lost (mclk_lost),
  .por_flag  (por_flag),
  .fs_rise   (fs_rise),
  .wr_fire   (wr_fire),
  .up_fire   (up_fire),
  .cfg       ({por_flag, cfg_compand, mic_sel, pre_gain_hi, pga_step})
);

// File: tb/codec_pwr_seq_tb.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_b = 1'b0, csn_b = 1'b1, sdi_b = 1'b0;
  logic mclk_b = 1'b0, fs_b = 1'b0, slot_b = 1'b0;
  logic mclk_run = 1'b1;
  int   mdiv = 0;

  logic       pwr_on, tx_oe, mclk_lost, por_flag, cfg_compand, pre_gain_hi;
  logic [1:0] mic_sel;
  logic [3:0] pga_step;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_pwr_seq #(.NREG(8), .TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst(rst), .ctl_sclk(sclk_b), .ctl_csn(csn_b), .ctl_sdi(sdi_b),
    .mclk(mclk_b), .fsync(fs_b), .tx_slot(slot_b),
    .pwr_on(pwr_on), .tx_oe(tx_oe), .mclk_lost(mclk_lost), .por_flag(por_flag),
    .cfg_compand(cfg_compand), .mic_sel(mic_sel), .pre_gain_hi(pre_gain_hi),
    .pga_step(pga_step)
  );

  // behavioural reference model
  logic [7:0]  m_reg [8];
  logic [15:0] m_shift;
  int          m_cnt, m_idle, m_fs;
  bit          m_pwr, m_oe, m_lost;
  bit          p_sclk, p_csn, p_mclk, p_fs;
  logic [11:0] exp1, exp2, exp3;
  logic [1:0]  rh = 2'b11;

  function automatic logic [11:0] m_out();
    return {m_pwr, m_oe, m_lost, ~m_reg[1][0], m_reg[0][0], m_reg[4][7:6],
            m_reg[4][1], m_reg[5][7:4]};
  endfunction

  always @(posedge clk) begin
    bit sr, cf, cr, fr, up, dn;
    cyc++;
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
      m_reg[0] = 8'h01;
      m_reg[5] = 8'h80;
      m_shift = '0; m_cnt = 0; m_idle = 0; m_fs = 0;
      m_pwr = 0; m_oe = 0; m_lost = 0;
      p_sclk = 0; p_csn = 1; p_mclk = 0; p_fs = 0;
    end else begin
      sr = sclk_b && !p_sclk;
      cf = !csn_b && p_csn;
      cr = csn_b && !p_csn;
      fr = fs_b && !p_fs;
      up = 0; dn = 0;
      if (cr) begin
        if (m_cnt == 8 && m_shift[1] == 1'b0) begin
          if (m_shift[2]) dn = 1; else up = 1;
        end else if (m_cnt == 16 && m_shift[9] && m_shift[15:11] < 5'd8) begin
          m_reg[m_shift[13:11]] = m_shift[7:0];
          if (m_shift[10]) dn = 1; else up = 1;
        end
      end
      if (cf) m_cnt = 0;
      else if (sr && !csn_b) begin
        m_shift = {m_shift[14:0], sdi_b};
        if (m_cnt < 31) m_cnt++;
      end
      if (mclk_b != p_mclk) m_idle = 0;
      else if (m_idle < TMO) m_idle++;
      m_lost = (m_idle >= TMO);
      if (m_lost || dn)         begin m_pwr = 0; m_fs = 0; end
      else if (up && !m_pwr)    begin m_pwr = 1; m_fs = 0; end
      else if (fr && m_pwr && m_fs < 2) m_fs++;
      m_oe = m_pwr && (m_fs == 2) && slot_b;
      p_sclk = sclk_b; p_csn = csn_b; p_mclk = mclk_b; p_fs = fs_b;
    end
    exp3 = exp2; exp2 = exp1; exp1 = m_out();
    rh = {rh[0], rst};
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model, three edges behind
  always @(negedge clk) begin
    if (!done && cyc > 3 && rh == 2'b00) begin
      chk("R2 pwr_on model",    int'(pwr_on),    int'(exp3[11]));
      chk("R5 tx_oe model",     int'(tx_oe),     int'(exp3[10]));
      chk("R6 mclk_lost model", int'(mclk_lost), int'(exp3[9]));
      chk("R7 por_flag model",  int'(por_flag),  int'(exp3[8]));
      chk("R8 cfg fields model",
          int'({cfg_compand, mic_sel, pre_gain_hi, pga_step}), int'(exp3[7:0]));
    end
  end

  always @(negedge clk) begin
    if (mclk_run) begin
      mdiv++;
      if (mdiv >= 2) begin mdiv = 0; mclk_b = ~mclk_b; end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    csn_b = 1'b0; idle(3);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_b = v[i]; sclk_b = 1'b0; idle(3);
      sclk_b = 1'b1; idle(3);
    end
    sclk_b = 1'b0; idle(3);
    csn_b = 1'b1; idle(6);
  endtask

  task automatic fs_pulse();
    fs_b = 1'b1; idle(1);
    fs_b = 1'b0; idle(6);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    idle(4);
    chk("R1 pwr_on after reset", pwr_on, 0);
    chk("R1 tx_oe after reset", tx_oe, 0);
    chk("R1 por_flag after reset", por_flag, 1);
    chk("R1 default fields", {cfg_compand, mic_sel, pre_gain_hi, pga_step}, 9'b1_00_0_1000);

    send(16'h2EA0, 16);                       // reg5 = A0, stay down
    chk("R2 gain written", pga_step, 4'hA);
    chk("R2 P=1 keeps down", pwr_on, 0);
    send(16'h2682, 16);                       // reg4 = 82
    chk("R8 mic_sel", mic_sel, 2);
    chk("R8 pre_gain_hi", pre_gain_hi, 1);
    send(16'h0700, 16);                       // reg0 = 00, bit0 reserved set
    chk("R8 linear coding", cfg_compand, 0);

    send(16'h0A5, 12);                        // bad length
    send(16'h24FF, 16);                       // long frame without marker
    send(16'h4EFF, 16);                       // address 9
    send(16'h0002, 8);                        // short with marker, P=0
    chk("R4 fields untouched", {mic_sel, pre_gain_hi, pga_step}, 7'b10_1_1010);
    chk("R3 short with marker ignored", pwr_on, 0);

    send(16'h0000, 8);                        // power up
    chk("R3 short power up", pwr_on, 1);
    slot_b = 1'b1; idle(4);
    chk("R5 oe before fs", tx_oe, 0);
    fs_pulse();
    chk("R5 oe after first fs", tx_oe, 0);
    fs_pulse();
    chk("R5 oe after second fs", tx_oe, 1);
    slot_b = 1'b0; idle(4);
    chk("R5 oe follows slot", tx_oe, 0);

    send(16'h2642, 16);                       // write + power down
    chk("R2 write with P=1 powers down", pwr_on, 0);
    chk("R4 retained in power down", pga_step, 4'hA);
    send(16'h2240, 16);                       // write + power up
    chk("R2 write with P=0 powers up", pwr_on, 1);
    slot_b = 1'b1;
    fs_pulse(); fs_pulse();
    chk("R5 oe after two fs again", tx_oe, 1);

    send(16'h0A01, 16);                       // flag bit set
    chk("R7 flag cleared", por_flag, 0);
    rst = 1'b1; idle(3); rst = 1'b0; idle(4);
    chk("R7 flag set by reset", por_flag, 1);
    chk("R1 fields back to default", {cfg_compand, mic_sel, pre_gain_hi, pga_step}, 9'b1_00_0_1000);
    chk("R1 down after reset", pwr_on, 0);

    send(16'h0000, 8);
    fs_pulse(); fs_pulse();
    chk("R5 live before stall", tx_oe, 1);
    mclk_run = 1'b0; idle(TMO + 6);
    chk("R6 lost raised", mclk_lost, 1);
    chk("R6 forced down", pwr_on, 0);
    chk("R6 oe dropped", tx_oe, 0);
    send(16'h0000, 8);
    chk("R6 up refused while lost", pwr_on, 0);
    mclk_run = 1'b1; idle(10);
    chk("R6 lost cleared", mclk_lost, 0);
    chk("R6 stays down after resume", pwr_on, 0);
    send(16'h0000, 8);
    chk("R6 up after resume", pwr_on, 1);
    idle(10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected completion sooner", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule